// File: doc/BRIEF.md
# NAND Sector Single-Bit Hamming ECC

This block protects a 512-byte NAND sector with a 24-bit Hamming-style code. It has two parts. The encoder watches bytes stream past, each with its byte index, and folds them into two 12-bit parity accumulators. Every data bit has a 12-bit address: the byte index in the upper nine bits and the bit number in the lower three. For each address bit, one accumulator keeps the parity of the bits whose address has that bit set. The other keeps the parity of the bits whose address has it clear. A done pulse packs the two halves and inverts them, so that a fully erased (all-ones) sector produces the same code that an erased spare area holds.

The decoder takes a code read back from the spare area and a code freshly computed over the read data. It classifies the sector into one of four classes: clean, a single data bit in error, a single bit in error in the stored code, or uncorrectable. For a data error it reports the byte index and the bit number to flip. The flip itself, and the sector buffer, belong to the surrounding datapath. If a correctable pattern names a byte at or beyond the sector size, which can happen only with a sector size that is not a power of two, the decoder reports it as uncorrectable.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset, `code_valid` and `res_valid` are low, and `code`, `res_status`, `res_byte` and `res_bit` are zero.
- R2: For each k in 0..11, `code[12+k]` is the inverse of the parity of all data bits whose address {byte index, bit number} has bit k set. `code[k]` is the inverse of the parity of the bits whose address has bit k clear. `code[7:0]` is the first byte stored. `code_valid` is high for exactly the one cycle after a `gen_done` pulse, and `code` holds its value until the next pulse.
- R3: A sector of all 0xFF bytes and a sector of all 0x00 bytes both give code 0xFFFFFF.
- R4: `gen_start` discards everything accumulated before it. A byte presented in the same cycle as `gen_start` counts as the first byte of the new sector.
- R5: When `chk_stored` equals `chk_calc`, the status is 0 (clean).
- R6: Let d = `chk_stored` ^ `chk_calc`. When d[23:12] ^ d[11:0] equals 0xFFF, the status is 1 (data bit error), `res_byte` is d[23:15] and `res_bit` is d[14:12].
- R7: When d has exactly one bit set, the status is 2 (error in the stored code only), and `res_byte` and `res_bit` are zero.
- R8: Any other nonzero d gives status 3 (uncorrectable). For every status other than 1, the location outputs are zero.
- R9: `res_valid` is high for exactly the one cycle after a `chk_valid` cycle. The result fields hold their value until the next check.
- R10: Cycles with `gen_valid` low leave the code unchanged, whatever `gen_data` and `gen_index` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_start | input | 1 | Clears the parity accumulators |
| gen_valid | input | 1 | `gen_data` carries a sector byte this cycle |
| gen_index | input | 9 | Byte index of `gen_data` within the sector |
| gen_data | input | 8 | Sector byte |
| gen_done | input | 1 | Latches the packed, inverted code |
| code_valid | output | 1 | One-cycle strobe: `code` is new |
| code | output | 24 | Sector code, bits 7:0 stored first |
| chk_valid | input | 1 | Starts a classification of the two codes |
| chk_stored | input | 24 | Code read back from the spare area |
| chk_calc | input | 24 | Code computed over the read data |
| res_valid | output | 1 | One-cycle strobe: result fields are new |
| res_status | output | 2 | 0 clean, 1 data bit, 2 code bit, 3 uncorrectable |
| res_byte | output | 9 | Byte index to flip (status 1) |
| res_bit | output | 3 | Bit number to flip (status 1) |

## Verification
Both results come out one register stage after their trigger. The code appears in the cycle after the clock edge that samples `gen_done`, and the classification appears in the cycle after the edge that samples `chk_valid`. The bench drives inputs on the falling edge and reads outputs on the next falling edge. Each result is therefore checked half a cycle after the edge that produced it. A further falling-edge sample confirms that each strobe has dropped again after its single cycle.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_FIX_DATA = 2'd1,
        ST_FIX_CODE = 2'd2,
        ST_FATAL    = 2'd3
    } ecc_status_e;

endpackage

// File: rtl/nand_ecc_parity_gen.sv
module nand_ecc_parity_gen #(
    parameter  int SECTOR_BYTES = 512,
    localparam int IDX_W        = $clog2(SECTOR_BYTES),
    localparam int ADDR_W       = IDX_W + 3,
    localparam int CODE_W       = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [IDX_W-1:0]  index_i,
    input  logic [7:0]        data_i,
    input  logic              done_i,
    output logic              code_valid_o,
    output logic [CODE_W-1:0] code_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] par_set;
        logic [ADDR_W-1:0] par_clr;
        logic              code_vld;
        logic [CODE_W-1:0] code;
    } gen_state_t;

    gen_state_t st_d, st_q;

    always_comb begin
        logic [ADDR_W-1:0] bit_addr;
        st_d     = st_q;
        bit_addr = '0;
        if (start_i) begin
            st_d.par_set = '0;
            st_d.par_clr = '0;
        end
        if (valid_i) begin
            for (int j = 0; j < 8; j++) begin
                bit_addr = {index_i, j[2:0]};
                if (data_i[j]) begin
                    st_d.par_set = st_d.par_set ^ bit_addr;
                    st_d.par_clr = st_d.par_clr ^ ~bit_addr;
                end
            end
        end
        st_d.code_vld = done_i;
        if (done_i) begin
            st_d.code = ~{st_d.par_set, st_d.par_clr};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_valid_o = st_q.code_vld;
    assign code_o       = st_q.code;

    AST_CODE_STROBE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> code_valid_o);  // R2
    AST_CODE_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> !code_valid_o);  // R2
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(code_o));  // R2
    AST_EMPTY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_i) ##1 (done_i && !valid_i && !start_i) |=> code_o == '1);  // R4

endmodule

// File: rtl/nand_ecc_syndrome.sv
module nand_ecc_syndrome #(
    parameter  int SECTOR_BYTES = 512,
    localparam int IDX_W        = $clog2(SECTOR_BYTES),
    localparam int ADDR_W       = IDX_W + 3,
    localparam int CODE_W       = 2 * ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chk_valid_i,
    input  logic [CODE_W-1:0]        stored_i,
    input  logic [CODE_W-1:0]        calc_i,
    output logic                     res_valid_o,
    output nand_ecc_pkg::ecc_status_e status_o,
    output logic [IDX_W-1:0]         byte_o,
    output logic [2:0]               bit_o
);
    import nand_ecc_pkg::*;

    localparam logic [IDX_W:0] SECTOR_LIM = SECTOR_BYTES[IDX_W:0];

    typedef struct packed {
        logic              vld;
        ecc_status_e       status;
        logic [IDX_W-1:0]  byte_idx;
        logic [2:0]        bit_idx;
    } chk_state_t;

    chk_state_t st_d, st_q;

    logic [CODE_W-1:0] diff;
    logic [ADDR_W-1:0] diff_hi, diff_lo;
    logic              single_bit;

    assign diff       = stored_i ^ calc_i;
    assign diff_hi    = diff[CODE_W-1:ADDR_W];
    assign diff_lo    = diff[ADDR_W-1:0];
    assign single_bit = (diff != '0) && ((diff & (diff - 1'b1)) == '0);

    always_comb begin
        st_d     = st_q;
        st_d.vld = chk_valid_i;
        if (chk_valid_i) begin
            st_d.byte_idx = '0;
            st_d.bit_idx  = '0;
            if (diff == '0) begin
                st_d.status = ST_CLEAN;
            end else if ((diff_hi ^ diff_lo) == '1) begin
                if ({1'b0, diff_hi[ADDR_W-1:3]} < SECTOR_LIM) begin
                    st_d.status   = ST_FIX_DATA;
                    st_d.byte_idx = diff_hi[ADDR_W-1:3];
                    st_d.bit_idx  = diff_hi[2:0];
                end else begin
                    st_d.status = ST_FATAL;
                end
            end else if (single_bit) begin
                st_d.status = ST_FIX_CODE;
            end else begin
                st_d.status = ST_FATAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid_o = st_q.vld;
    assign status_o    = st_q.status;
    assign byte_o      = st_q.byte_idx;
    assign bit_o       = st_q.bit_idx;

    AST_RES_STROBE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_i |=> res_valid_o);  // R9
    AST_RES_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid_i |=> !res_valid_o && $stable(status_o));  // R9
    AST_MATCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_i && (stored_i == calc_i) |=> status_o == ST_CLEAN);  // R5
    AST_CODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_i && ($countones(stored_i ^ calc_i) == 1) |=> status_o == ST_FIX_CODE);  // R7
    AST_NO_LOCATION: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && (status_o != ST_FIX_DATA) |-> (byte_o == '0) && (bit_o == '0));  // R8

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
    parameter  int SECTOR_BYTES = 512,
    localparam int IDX_W        = $clog2(SECTOR_BYTES),
    localparam int CODE_W       = 2 * (IDX_W + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_start,
    input  logic              gen_valid,
    input  logic [IDX_W-1:0]  gen_index,
    input  logic [7:0]        gen_data,
    input  logic              gen_done,
    output logic              code_valid,
    output logic [CODE_W-1:0] code,
    input  logic              chk_valid,
    input  logic [CODE_W-1:0] chk_stored,
    input  logic [CODE_W-1:0] chk_calc,
    output logic              res_valid,
    output logic [1:0]        res_status,
    output logic [IDX_W-1:0]  res_byte,
    output logic [2:0]        res_bit
);

    nand_ecc_pkg::ecc_status_e status_w;

    nand_ecc_parity_gen #(.SECTOR_BYTES(SECTOR_BYTES)) u_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (gen_start),
        .valid_i      (gen_valid),
        .index_i      (gen_index),
        .data_i       (gen_data),
        .done_i       (gen_done),
        .code_valid_o (code_valid),
        .code_o       (code)
    );

    nand_ecc_syndrome #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_valid_i (chk_valid),
        .stored_i    (chk_stored),
        .calc_i      (chk_calc),
        .res_valid_o (res_valid),
        .status_o    (status_w),
        .byte_o      (res_byte),
        .bit_o       (res_bit)
    );

    assign res_status = status_w;

endmodule

// File: tb/nand_hamming_ecc_bench.sv
module nand_hamming_ecc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_start = 1'b0, gen_valid = 1'b0, gen_done = 1'b0;
    logic [8:0]  gen_index = '0;
    logic [7:0]  gen_data = '0;
    logic        code_valid;
    logic [23:0] code;
    logic        chk_valid = 1'b0;
    logic [23:0] chk_stored = '0, chk_calc = '0;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [8:0]  res_byte;
    logic [2:0]  res_bit;

    int checks = 0;
    int errors = 0;
    logic [7:0] sec [0:511];

    always #2 clk = ~clk;

    nand_hamming_ecc u_nand_hamming_ecc (
        .clk(clk), .rst_n(rst_n),
        .gen_start(gen_start), .gen_valid(gen_valid), .gen_index(gen_index),
        .gen_data(gen_data), .gen_done(gen_done),
        .code_valid(code_valid), .code(code),
        .chk_valid(chk_valid), .chk_stored(chk_stored), .chk_calc(chk_calc),
        .res_valid(res_valid), .res_status(res_status),
        .res_byte(res_byte), .res_bit(res_bit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-address-bit parity, taken straight from the definition in R2.
    function automatic logic [23:0] model_code();
        logic [11:0] hi = '0, lo = '0;
        for (int k = 0; k < 12; k++) begin
            for (int i = 0; i < 512; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [11:0] a = {i[8:0], j[2:0]};
                    if (sec[i][j]) begin
                        if (a[k]) hi[k] = ~hi[k];
                        else      lo[k] = ~lo[k];
                    end
                end
            end
        end
        return ~{hi, lo};
    endfunction

    // Returns {status, byte, bit}.
    function automatic logic [13:0] model_class(input logic [23:0] s, input logic [23:0] c);
        logic [23:0] d = s ^ c;
        if (d == 0) return {2'd0, 12'd0};
        if ((d[23:12] ^ d[11:0]) == 12'hFFF) return {2'd1, d[23:15], d[14:12]};
        if ($countones(d) == 1) return {2'd2, 12'd0};
        return {2'd3, 12'd0};
    endfunction

    task automatic feed(input string tag, input bit gaps, input bit first_with_start);
        logic [23:0] exp = model_code();
        @(negedge clk);
        gen_start = 1'b1;
        if (first_with_start) begin
            gen_valid = 1'b1; gen_index = 9'd0; gen_data = sec[0];
        end
        @(negedge clk);
        gen_start = 1'b0;
        for (int i = (first_with_start ? 1 : 0); i < 512; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                gen_valid = 1'b0; gen_index = 9'($urandom); gen_data = 8'($urandom);  // R10
                @(negedge clk);
            end
            gen_valid = 1'b1; gen_index = i[8:0]; gen_data = sec[i];
            @(negedge clk);
        end
        gen_valid = 1'b0; gen_data = 8'($urandom); gen_done = 1'b1;
        @(negedge clk);
        gen_done = 1'b0;
        check({tag, " code_valid R2"}, 32'(code_valid), 32'd1);
        check({tag, " code"}, 32'(code), 32'(exp));
        @(negedge clk);
        check({tag, " code_valid drop R2"}, 32'(code_valid), 32'd0);
    endtask

    task automatic classify(input string tag, input logic [23:0] s, input logic [23:0] c,
                            input logic [13:0] exp);
        chk_valid = 1'b1; chk_stored = s; chk_calc = c;
        @(negedge clk);
        chk_valid = 1'b0; chk_stored = 24'($urandom); chk_calc = 24'($urandom);
        check({tag, " res_valid R9"}, 32'(res_valid), 32'd1);
        check({tag, " result"}, 32'({res_status, res_byte, res_bit}), 32'(exp));
    endtask

    logic [23:0] c0, c1;
    int unsigned seed_dummy;

    initial begin
        seed_dummy = $urandom(32'h1234_5EED);
        repeat (3) @(negedge clk);
        check("R1 code_valid", 32'(code_valid), 0);
        check("R1 res_valid", 32'(res_valid), 0);
        check("R1 fields", 32'({code, res_status, res_byte, res_bit}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 512; i++) sec[i] = 8'hFF;
        feed("R3 erased", 1'b0, 1'b0);
        check("R3 erased const", 32'(code), 32'hFFFFFF);
        for (int i = 0; i < 512; i++) sec[i] = 8'h00;
        feed("R3 zeros", 1'b0, 1'b0);
        check("R3 zeros const", 32'(code), 32'hFFFFFF);

        // Leave junk in the accumulators, then restart with the first byte on start.
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); gen_valid = 1'b1; gen_index = 9'($urandom); gen_data = 8'($urandom);
        end
        @(negedge clk); gen_valid = 1'b0;
        for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
        feed("R4 restart", 1'b0, 1'b1);
        feed("R2 R10 gaps", 1'b1, 1'b0);
        c0 = code;

        // Flip one data bit and let the hardware find it.
        sec[300][5] = ~sec[300][5];
        feed("R2 flipped", 1'b0, 1'b0);
        c1 = code;
        classify("R6 hw flip", c0, c1, {2'd1, 9'd300, 3'd5});
        @(negedge clk);
        check("R9 res_valid drop", 32'(res_valid), 0);
        sec[300][5] = ~sec[300][5];

        // Corner flip positions, codes from the model.
        c0 = model_code();
        sec[0][0] = ~sec[0][0]; c1 = model_code(); sec[0][0] = ~sec[0][0];
        classify("R6 byte0 bit0", c0, c1, {2'd1, 9'd0, 3'd0});
        sec[511][7] = ~sec[511][7]; c1 = model_code(); sec[511][7] = ~sec[511][7];
        classify("R6 byte511 bit7", c0, c1, {2'd1, 9'd511, 3'd7});
        sec[7][1] = ~sec[7][1]; sec[400][6] = ~sec[400][6]; c1 = model_code();
        classify("R8 double flip", c0, c1, {2'd3, 12'd0});

        classify("R5 equal", c0, c0, {2'd0, 12'd0});
        for (int b = 0; b < 24; b++)
            classify("R7 code bit", c0, c0 ^ (24'd1 << b), {2'd2, 12'd0});
        classify("R8 two code bits", 24'h000003, 24'h0, {2'd3, 12'd0});

        for (int n = 0; n < 300; n++) begin
            logic [23:0] s = 24'($urandom);
            logic [23:0] c;
            case ($urandom % 4)
                0: c = s;
                1: begin
                    logic [11:0] a = 12'($urandom);
                    c = s ^ {a, ~a};
                end
                2: c = s ^ (24'd1 << ($urandom % 24));
                default: c = 24'($urandom);
            endcase
            classify("R5 R6 R7 R8 random", s, c, model_class(s, c));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule